// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects a synchronous request port to an external asynchronous static RAM that holds 131,072 bytes. A client places a read or a write on the port with a valid/ready handshake. The block then produces the memory's active-low chip select, write strobe and output-enable strobe, the 17-bit address and an 8-bit data bus. The data bus is split into a driven value, a driver enable and a sampled input, so that a pad cell or a testbench model can resolve it.

Each access runs as a fixed series of phases whose lengths are parameters counted in clock cycles: address setup, write-strobe low, write recovery, read wait and bus turnaround. The defaults meet a 12 ns memory at a 100 MHz clock. Writes are controlled by the write strobe. The address and the write data are loaded only while the chip is deselected, and they hold still for the whole access. Every memory-facing pin comes straight from a flip-flop. Read data comes back on a one-cycle response strobe.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, chip select, write strobe and output-enable strobe are high (inactive), the data driver is off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A write accepted while idle is followed by SETUP_CYC cycles with chip select low, write strobe high and the data driver on. Then come WE_CYC cycles with the write strobe low, then REC_CYC cycles with the write strobe high and the driver still on. After that the block is idle again.
- R3: The address and the write data on the memory pins do not change from the first cycle of chip select low until chip select returns high. In particular they hold through every write-strobe-low cycle and through the write-strobe rising edge.
- R4: A read accepted while idle is followed by SETUP_CYC cycles with chip select low and output enable high, then RD_CYC cycles with output enable low. The data bus is sampled at the clock edge that ends the last output-enable-low cycle.
- R5: The data driver is never on while output enable is low, nor in the cycle right after a cycle with output enable low.
- R6: A write accepted when the previous access was a read first spends TURN_CYC cycles with chip select low, output enable high and the driver off. A write that follows a write, or that is the first access after reset, spends none.
- R7: `req_ready` is 0 from the cycle after a request is accepted until the access sequence ends, and chip select is never low while `req_ready` is 1.
- R8: `rsp_valid` pulses for exactly one cycle per read, one cycle after the sampling edge, carrying the sampled byte on `rsp_rdata`; writes produce no pulse.
- R9: A read returns the byte most recently written to the same address, including the lowest (0) and highest (17'h1FFFF) addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_o | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_i | input | 8 | Value sampled from the data bus |

## Verification
The bench targets three hazards. The first is a write issued straight after a read: without the turnaround gap, the controller's driver would overlap the memory still driving the bus, and the bus model reports that contention. The second is the write strobe's rising edge: if the address or data moved during the low phase or at its end, the model would store the wrong byte at the wrong address, and later read-backs would differ from the reference. The third is read sampling and the response strobe: a capture one cycle early, or a strobe that lasts two cycles or appears after writes, shows up as a mismatched or unexpected scoreboard item. The bench also exercises both address extremes.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_RD_SETUP   = 3'd1,
      ST_RD_WAIT    = 3'd2,
      ST_RD_CAPTURE = 3'd3,
      ST_TURN       = 3'd4,
      ST_WR_SETUP   = 3'd5,
      ST_WR_PULSE   = 3'd6,
      ST_WR_RECOVER = 3'd7
   } seq_st_t;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic drv;
   } pin_set_t;

   // Pin levels the memory sees while the sequencer sits in a given state.
   function automatic pin_set_t pins_of(seq_st_t s);
      pin_set_t p;
      p = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
      case (s)
         ST_RD_SETUP:   p.ce_n = 1'b0;
         ST_RD_WAIT:    begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
         ST_TURN:       p.ce_n = 1'b0;
         ST_WR_SETUP:   begin p.ce_n = 1'b0; p.drv = 1'b1; end
         ST_WR_PULSE:   begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drv = 1'b1; end
         ST_WR_RECOVER: begin p.ce_n = 1'b0; p.drv = 1'b1; end
         default:       ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] len,
   output logic          done
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= len - CW'(1);
      else if (cnt != '0)
         cnt <= cnt - CW'(1);
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
   import asram_pkg::*;
#(
   parameter int SETUP_CYC = 1,
   parameter int WE_CYC    = 1,
   parameter int REC_CYC   = 1,
   parameter int RD_CYC    = 2,
   parameter int TURN_CYC  = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_valid,
   input  logic    req_write,
   output logic    req_ready,
   output seq_st_t state,
   output seq_st_t nxt
);

   localparam int MAXA = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
   localparam int MAXB = (REC_CYC > RD_CYC) ? REC_CYC : RD_CYC;
   localparam int MAXC = (MAXA > MAXB) ? MAXA : MAXB;
   localparam int MAXP = (MAXC > TURN_CYC) ? MAXC : TURN_CYC;
   localparam int CW   = $clog2(MAXP + 1);

   logic          done;
   logic          load;
   logic [CW-1:0] len;
   logic          after_rd;
   logic          accept;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;

   // Optional turnaround: the read-history flag exists only when a gap is configured.
   generate
      if (TURN_CYC > 0) begin : g_turn
         logic rd_flag;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rd_flag <= 1'b0;
            else if (state == ST_RD_CAPTURE)
               rd_flag <= 1'b1;
            else if (accept && req_write)
               rd_flag <= 1'b0;
         end
         assign after_rd = rd_flag;
      end else begin : g_no_turn
         assign after_rd = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:
            if (req_valid)
               nxt = !req_write ? ST_RD_SETUP : (after_rd ? ST_TURN : ST_WR_SETUP);
         ST_RD_SETUP:   if (done) nxt = ST_RD_WAIT;
         ST_RD_WAIT:    if (done) nxt = ST_RD_CAPTURE;
         ST_RD_CAPTURE: nxt = ST_IDLE;
         ST_TURN:       if (done) nxt = ST_WR_SETUP;
         ST_WR_SETUP:   if (done) nxt = ST_WR_PULSE;
         ST_WR_PULSE:   if (done) nxt = ST_WR_RECOVER;
         ST_WR_RECOVER: if (done) nxt = ST_IDLE;
         default:       nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      case (nxt)
         ST_RD_SETUP, ST_WR_SETUP: len = CW'(SETUP_CYC);
         ST_RD_WAIT:               len = CW'(RD_CYC);
         ST_TURN:                  len = CW'(TURN_CYC);
         ST_WR_PULSE:              len = CW'(WE_CYC);
         ST_WR_RECOVER:            len = CW'(REC_CYC);
         default:                  len = CW'(1);
      endcase
   end

   assign load = (nxt != state);

   asram_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .len   (len),
      .done  (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_IDLE;
      else
         state <= nxt;
   end

   // R6: a write must never reach its setup phase straight from a read capture.
   assert_turn_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (TURN_CYC > 0 && state == ST_WR_SETUP && $past(state) != ST_WR_SETUP)
         |-> $past(state) != ST_RD_CAPTURE && $past(state) != ST_RD_WAIT);

   // R4: leaving the output-enable phase always leads to a capture.
   assert_wait_to_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_RD_WAIT && state != ST_RD_WAIT) |-> state == ST_RD_CAPTURE);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int AW        = 17,
   parameter int DW        = 8,
   parameter int SETUP_CYC = 1,
   parameter int WE_CYC    = 1,
   parameter int REC_CYC   = 1,
   parameter int RD_CYC    = 2,
   parameter int TURN_CYC  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          mem_ce_n,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_o,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_i
);

   generate
      if (SETUP_CYC < 1 || WE_CYC < 1 || REC_CYC < 1 || RD_CYC < 1)
         begin : g_bad_phase
            $error("asram_ctrl: setup, strobe, recovery and read phases need at least one cycle");
         end
      if (TURN_CYC < 0) begin : g_bad_turn
         $error("asram_ctrl: turnaround length cannot be negative");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("asram_ctrl: address and data widths must be positive");
      end
   endgenerate

   seq_st_t  state;
   seq_st_t  nxt;
   pin_set_t nxt_pins;
   logic     accept;

   asram_fsm #(
      .SETUP_CYC (SETUP_CYC),
      .WE_CYC    (WE_CYC),
      .REC_CYC   (REC_CYC),
      .RD_CYC    (RD_CYC),
      .TURN_CYC  (TURN_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_ready (req_ready),
      .state     (state),
      .nxt       (nxt)
   );

   assign accept   = req_valid && req_ready;
   assign nxt_pins = pins_of(nxt);

   // Strobes registered from the next state: glitch-free at the pads.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ce_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else begin
         mem_ce_n  <= nxt_pins.ce_n;
         mem_we_n  <= nxt_pins.we_n;
         mem_oe_n  <= nxt_pins.oe_n;
         mem_dq_oe <= nxt_pins.drv;
      end
   end

   // Address and write data load only on acceptance, while the chip is deselected.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dq_o <= '0;
      end else if (accept) begin
         mem_addr <= req_addr;
         mem_dq_o <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= (nxt == ST_RD_CAPTURE) && (state == ST_RD_WAIT);
         if (state == ST_RD_WAIT && nxt == ST_RD_CAPTURE)
            rsp_rdata <= mem_dq_i;
      end
   end

   assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   assert_strobe_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n));

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

   assert_we_rise_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_o)));

   assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

   assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready);

   assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_rsp_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!mem_oe_n));

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

   localparam int AW = 17;
   localparam int DW = 8;
   localparam int S  = 1;
   localparam int W  = 1;
   localparam int RC = 1;
   localparam int RD = 2;
   localparam int T  = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_o;
   logic [DW-1:0] mem_dq_i;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   asram_ctrl #(
      .AW(AW), .DW(DW), .SETUP_CYC(S), .WE_CYC(W), .REC_CYC(RC), .RD_CYC(RD), .TURN_CYC(T)
   ) u_asram_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i)
   );

   // ---- behavioural memory model ----
   logic [DW-1:0] sram [int];
   logic [DW-1:0] refm [int];
   logic          mdrive;
   int            model_viol = 0;
   logic [AW-1:0] prev_addr = '0;
   logic [DW-1:0] prev_dq = '0;
   logic          prev_we_n = 1'b1;

   always @(mem_addr, mem_ce_n, mem_we_n, mem_oe_n) begin
      mdrive = !mem_ce_n && mem_we_n && !mem_oe_n;
      if (mdrive && sram.exists(int'(mem_addr))) mem_dq_i = sram[int'(mem_addr)];
      else mem_dq_i = '0;
   end

   always @(posedge mem_we_n) begin
      if (rst_n && !mem_ce_n) sram[int'(mem_addr)] = mem_dq_o;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (mdrive && mem_dq_oe) begin
            model_viol++;
            $display("FAIL R5: bus contention at addr %h (actual both drive, expected one)", mem_addr);
         end
         if (!prev_we_n && (mem_addr != prev_addr || mem_dq_o != prev_dq)) begin
            model_viol++;
            $display("FAIL R3: addr/data moved during write strobe: actual %h/%h expected %h/%h",
                     mem_addr, mem_dq_o, prev_addr, prev_dq);
         end
      end
      prev_addr = mem_addr;
      prev_dq   = mem_dq_o;
      prev_we_n = mem_we_n;
   end

   // ---- scoreboard ----
   logic [DW-1:0] exp_q [$];

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R8: response strobe with no read pending: actual %h expected none", rsp_rdata);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            if (rsp_rdata !== e) begin
               errors++;
               $display("FAIL R9: read data actual %h expected %h", rsp_rdata, e);
            end
         end
      end
   end

   // ---- driver ----
   logic last_rd = 1'b0;

   task automatic chk_pins(input string tag, input int k, input logic [4:0] exp, inout int bad);
      logic [4:0] act;
      act = {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready};
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: cycle %0d pins {ce_n,we_n,oe_n,drv,ready} actual %b expected %b",
                  tag, k, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      int bad = 0;
      int k = 0;
      int tc;
      string tag;
      tc  = last_rd ? T : 0;
      tag = last_rd ? "R6" : "R2";
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < tc; i++) begin
         k++; chk_pins(tag, k, 5'b01100, bad); @(negedge clk);
      end
      for (int i = 0; i < S; i++) begin
         k++; chk_pins(tag, k, 5'b01110, bad); @(negedge clk);
      end
      for (int i = 0; i < W; i++) begin
         k++; chk_pins(tag, k, 5'b00110, bad); @(negedge clk);
      end
      for (int i = 0; i < RC; i++) begin
         k++; chk_pins(tag, k, 5'b01110, bad); @(negedge clk);
      end
      k++; chk_pins("R1", k, 5'b11101, bad);
      checks++;
      if (bad != 0) errors++;
      refm[int'(a)] = d;
      last_rd = 1'b0;
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      int bad = 0;
      int k = 0;
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      exp_q.push_back(refm.exists(int'(a)) ? refm[int'(a)] : '0);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < S; i++) begin
         k++; chk_pins("R4", k, 5'b01100, bad); @(negedge clk);
      end
      for (int i = 0; i < RD; i++) begin
         k++; chk_pins("R4", k, 5'b01000, bad);
         if (rsp_valid !== 1'b0) begin
            bad++; $display("FAIL R8: early response at cycle %0d actual 1 expected 0", k);
         end
         @(negedge clk);
      end
      k++; chk_pins("R7", k, 5'b11100, bad);
      if (rsp_valid !== 1'b1) begin
         bad++; $display("FAIL R8: response strobe actual %b expected 1", rsp_valid);
      end
      @(negedge clk);
      k++; chk_pins("R1", k, 5'b11101, bad);
      if (rsp_valid !== 1'b0) begin
         bad++; $display("FAIL R8: response strobe too long actual %b expected 0", rsp_valid);
      end
      checks++;
      if (bad != 0) errors++;
      last_rd = 1'b1;
   endtask

   task automatic finish_run();
      checks++;
      if (model_viol != 0) errors++;
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R8: %0d reads without response, expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #400000;
      checks++; errors++;
      $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if ({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid} !== 6'b111010) begin
         errors++;
         $display("FAIL R1: reset pins actual %b expected 111010",
                  {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid});
      end
      rst_n = 1'b1;
      @(negedge clk);

      do_write(17'h00123, 8'hA5);     // R2 first access, no gap
      do_write(17'h00000, 8'h3C);     // R2 write after write, no gap; R9 low address
      do_write(17'h1FFFF, 8'hC3);     // R9 high address
      do_read(17'h00123);             // R4
      do_read(17'h1FFFF);             // R4 read after read
      do_write(17'h00123, 8'h5A);     // R6 turnaround after read
      do_read(17'h00123);             // R9 overwritten value
      do_read(17'h00000);             // R9 low address
      do_read(17'h00777);             // R9 never written, expects 0
      do_write(17'h1FFFF, 8'h00);     // R6 again
      do_read(17'h1FFFF);

      lfsr = 16'hACE1;
      for (int i = 0; i < 40; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[0]) do_write({13'h0, lfsr[4:1]} ^ 17'h10000, lfsr[15:8]);
         else         do_read({13'h0, lfsr[5:2]} ^ 17'h10000);
      end

      // R7: a request held idle-side is taken only when ready; idle gap keeps standby
      repeat (4) @(negedge clk);
      checks++;
      if ({mem_ce_n, req_ready} !== 2'b11) begin
         errors++;
         $display("FAIL R7: idle gap actual %b expected 11", {mem_ce_n, req_ready});
      end
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule